// File: doc/BRIEF.md
# Block Transfer Sequencer for Multi-Register Load and Store

This block turns one multi-register memory instruction into a train of single-word transfers. It is given a 16-bit register selection mask, a base address, a load/store select, one of four address-stepping modes and a writeback flag. It then walks the selected registers one at a time. For each one it presents a word address and a register index to an external memory and register file.

Every beat waits for the memory ready input before the walk moves on. When the last beat is accepted, the block pulses `done` for one cycle. If writeback was requested, it also presents the updated base address on `wb_addr`. Stack push is a store in decrement-before mode with writeback. Stack pop is a load in increment-after mode with writeback.

Data words never pass through this block. The surrounding datapath moves the data, using `xfer_idx` and `xfer_wr`.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset, `busy`, `xfer_vld`, `done` and `wb_vld` are all low.
- R2: Mask bit i selects register i. Each selected register appears exactly once as `xfer_idx` (4-bit binary index) and unselected ones never appear. `xfer_wr` is 1 for a store and 0 for a load (`is_load`=1).
- R3: `mode` encodes 0 = increment-after, 1 = increment-before, 2 = decrement-after, 3 = decrement-before. With n selected registers, the words used are n successive addresses, 4 bytes apart. The lowest of them is base for mode 0, base+4 for mode 1, base-4n+4 for mode 2 and base-4n for mode 3.
- R4: In every mode a lower-numbered register uses a lower address than a higher-numbered one.
- R5: Loads and increment-mode stores visit registers in ascending index order. Decrement-mode stores visit them in descending order.
- R6: `wb_vld` pulses together with `done` exactly when `wb_en` was set at start. `wb_addr` then equals base+4n for modes 0 and 1 and base-4n for modes 2 and 3.
- R7: An empty mask produces no beat. `done` rises in the cycle after start, and the written-back address equals the base.
- R8: A beat holds its address and index while `mem_rdy` is low. With `mem_rdy` high, the next beat follows in the next cycle with no gap.
- R9: `done` is a single-cycle pulse in the cycle after the final beat is accepted. `busy` is low in that cycle.
- R10: A `start` that arrives while `busy` is high is ignored and does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer when idle |
| is_load | input | 1 | 1 = load from memory, 0 = store |
| mode | input | 2 | Address-stepping mode (see R3) |
| wb_en | input | 1 | Request base writeback |
| reg_mask | input | 16 | Register selection mask |
| base_addr | input | 32 | Base address |
| mem_rdy | input | 1 | Memory accepts the current beat |
| busy | output | 1 | Sequence in progress |
| xfer_vld | output | 1 | A beat is presented |
| xfer_wr | output | 1 | Beat is a store |
| xfer_addr | output | 32 | Word address of the beat |
| xfer_idx | output | 4 | Register index of the beat |
| done | output | 1 | Completion pulse |
| wb_vld | output | 1 | Writeback value valid |
| wb_addr | output | 32 | Updated base value |

## Verification
The assertions assume that `mem_rdy` is meaningful only while a beat is presented, and that the operation inputs are sampled only on the edge where an idle block sees `start`. The stimulus drives random masks, modes, directions and word-aligned bases, and holds them steady from one start to the next. It raises `mem_rdy` at random during beats and lowers it once `done` is seen. A single stray start is injected mid-run with `mem_rdy` held low in that cycle, so that no beat is accepted on the same edge.

// File: rtl/lsm_pkg.sv
package lsm_pkg;
  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } amode_t;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} seq_state_t;

  function automatic int unsigned ones_in(input logic [63:0] v, input int unsigned w);
    int unsigned c;
    c = 0;
    for (int unsigned i = 0; i < w; i++) c += int'(v[i]);
    return c;
  endfunction
endpackage

// File: rtl/bit_pick.sv
module bit_pick #(
  parameter int N  = 16,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  input  logic          from_top,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |vec;
    if (from_top) begin
      for (int i = 0; i < N; i++)
        if (vec[i]) idx = IW'(i);
    end else begin
      for (int i = N - 1; i >= 0; i--)
        if (vec[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/xfer_addr_calc.sv
module xfer_addr_calc
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int WORD_BYTES = 4,
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic [AW-1:0] base,
  input  amode_t        mode,
  input  logic          is_load,
  input  logic [CW-1:0] count,
  output logic [AW-1:0] first,
  output logic [AW-1:0] final_addr,
  output logic          desc
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);
  logic [AW-1:0] span, low;

  always_comb begin
    span = AW'(count) * STEP;
    unique case (mode)
      AM_INC_AFTER:  low = base;
      AM_INC_BEFORE: low = base + STEP;
      AM_DEC_AFTER:  low = base - span + STEP;
      default:       low = base - span;
    endcase
    desc = !is_load && mode[1];
    first = (desc && count != '0) ? low + span - STEP : low;
    final_addr = mode[1] ? base - span : base + span;
  end
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import lsm_pkg::*;
#(
  parameter int AW = 32,
  parameter int NREG = 16,
  parameter int WORD_BYTES = 4,
  localparam int IW = $clog2(NREG),
  localparam int CW = $clog2(NREG + 1)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            is_load,
  input  logic [1:0]      mode,
  input  logic            wb_en,
  input  logic [NREG-1:0] reg_mask,
  input  logic [AW-1:0]   base_addr,
  input  logic            mem_rdy,
  output logic            busy,
  output logic            xfer_vld,
  output logic            xfer_wr,
  output logic [AW-1:0]   xfer_addr,
  output logic [IW-1:0]   xfer_idx,
  output logic            done,
  output logic            wb_vld,
  output logic [AW-1:0]   wb_addr
);
  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  seq_state_t      state;
  logic [NREG-1:0] mask_q, scan_in;
  logic            desc_q, wben_q;
  logic [AW-1:0]   fin_q;
  logic [CW-1:0]   cnt;
  logic [AW-1:0]   calc_first, calc_final;
  logic            calc_desc, pick_any, scan_dir;
  logic [IW-1:0]   pick_idx;

  assign cnt = CW'(ones_in(64'(reg_mask), NREG));

  xfer_addr_calc #(.AW(AW), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_calc (
    .base(base_addr), .mode(amode_t'(mode)), .is_load(is_load), .count(cnt),
    .first(calc_first), .final_addr(calc_final), .desc(calc_desc)
  );

  assign scan_in  = (state == ST_IDLE) ? reg_mask
                                       : (mask_q & ~(NREG'(1) << xfer_idx));
  assign scan_dir = (state == ST_IDLE) ? calc_desc : desc_q;

  bit_pick #(.N(NREG)) u_pick (
    .vec(scan_in), .from_top(scan_dir), .idx(pick_idx), .any(pick_any)
  );

  assign busy = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      mask_q <= '0;
      desc_q <= 1'b0;
      wben_q <= 1'b0;
      fin_q <= '0;
      xfer_vld <= 1'b0;
      xfer_wr <= 1'b0;
      xfer_addr <= '0;
      xfer_idx <= '0;
      done <= 1'b0;
      wb_vld <= 1'b0;
      wb_addr <= '0;
    end else begin
      done <= 1'b0;
      wb_vld <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            desc_q <= calc_desc;
            wben_q <= wb_en;
            fin_q <= calc_final;
            xfer_wr <= !is_load;
            if (pick_any) begin
              state <= ST_RUN;
              mask_q <= reg_mask;
              xfer_vld <= 1'b1;
              xfer_idx <= pick_idx;
              xfer_addr <= calc_first;
            end else begin
              done <= 1'b1;
              wb_vld <= wb_en;
              wb_addr <= calc_final;
            end
          end
        end
        default: begin
          if (mem_rdy) begin
            mask_q <= scan_in;
            if (pick_any) begin
              xfer_idx <= pick_idx;
              xfer_addr <= desc_q ? xfer_addr - STEP : xfer_addr + STEP;
            end else begin
              state <= ST_IDLE;
              xfer_vld <= 1'b0;
              done <= 1'b1;
              wb_vld <= wben_q;
              wb_addr <= fin_q;
            end
          end
        end
      endcase
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !busy && !xfer_vld && !done && !wb_vld);
  // R8
  beat_hold_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_vld && !mem_rdy |=> xfer_vld && $stable(xfer_addr) && $stable(xfer_idx));
  // R3
  word_step_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_vld && mem_rdy |=> !xfer_vld || xfer_addr == $past(xfer_addr) + STEP
                                      || xfer_addr == $past(xfer_addr) - STEP);
  // R5
  order_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_vld && mem_rdy |=> !xfer_vld || (desc_q ? xfer_idx < $past(xfer_idx)
                                                 : xfer_idx > $past(xfer_idx)));
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);
  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (rst) done |-> !busy && !xfer_vld);
  // R6
  wb_with_done_chk: assert property (@(posedge clk) disable iff (rst) wb_vld |-> done);
  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy && start && !mem_rdy |=> busy && $stable(xfer_addr) && $stable(xfer_idx));
endmodule

// File: tb/blk_xfer_seq_tb.sv
module blk_xfer_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst = 1, start = 0, is_load = 0, wb_en = 0, mem_rdy = 0;
  logic [1:0]  mode = 0;
  logic [15:0] reg_mask = 0;
  logic [31:0] base_addr = 0;
  logic        busy, xfer_vld, xfer_wr, done, wb_vld;
  logic [31:0] xfer_addr, wb_addr;
  logic [3:0]  xfer_idx;

  int total = 0, bad = 0;
  int          exp_n;
  logic [3:0]  exp_idx [16];
  logic [31:0] exp_addr [16];
  logic [31:0] exp_wb;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_xfer_seq u_dut (
    .clk(clk), .rst(rst), .start(start), .is_load(is_load), .mode(mode),
    .wb_en(wb_en), .reg_mask(reg_mask), .base_addr(base_addr), .mem_rdy(mem_rdy),
    .busy(busy), .xfer_vld(xfer_vld), .xfer_wr(xfer_wr), .xfer_addr(xfer_addr),
    .xfer_idx(xfer_idx), .done(done), .wb_vld(wb_vld), .wb_addr(wb_addr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  // Expected beats from R2..R6: sorted by index, lowest address per mode, step 4.
  task automatic build_exp(input logic [15:0] m, input logic ld, input logic [1:0] md,
                           input logic [31:0] b);
    logic [3:0] asc [16];
    logic [31:0] low;
    int n = 0;
    for (int i = 0; i < 16; i++) if (m[i]) begin asc[n] = 4'(i); n++; end
    case (md)
      2'd0: low = b;
      2'd1: low = b + 4;
      2'd2: low = b - 32'(4*n) + 4;
      default: low = b - 32'(4*n);
    endcase
    exp_n = n;
    exp_wb = md[1] ? b - 32'(4*n) : b + 32'(4*n);
    for (int p = 0; p < n; p++) begin
      if (!ld && md[1]) begin
        exp_idx[p] = asc[n-1-p];
        exp_addr[p] = low + 32'(4*(n-1-p));
      end else begin
        exp_idx[p] = asc[p];
        exp_addr[p] = low + 32'(4*p);
      end
    end
  endtask

  task automatic run_op(input logic [15:0] m, input logic ld, input logic [1:0] md,
                        input logic wb, input logic [31:0] b, input bit stall, input bit poke);
    int k = 0;
    int it = 0;
    build_exp(m, ld, md, b);
    @(negedge clk);
    reg_mask = m; is_load = ld; mode = md; wb_en = wb; base_addr = b; start = 1;
    @(negedge clk);
    start = 0;
    forever begin
      if (it > 200) begin chk(0, "R9", "no done", 0, 1); break; end
      if (poke && it == 2) begin
        start = 0; reg_mask = m;
      end
      if (done) begin
        chk(k == exp_n, "R2", "beat count", 32'(k), 32'(exp_n));
        chk(!busy, "R9", "busy at done", 32'(busy), 0);
        chk(wb_vld == wb, "R6", "wb_vld", 32'(wb_vld), 32'(wb));
        if (wb) chk(wb_addr == exp_wb, exp_n == 0 ? "R7" : "R6", "wb_addr", wb_addr, exp_wb);
        mem_rdy = 0;
        break;
      end
      if (xfer_vld) begin
        if (k >= exp_n) begin
          chk(0, exp_n == 0 ? "R7" : "R2", "extra beat", 32'(xfer_idx), 0);
          mem_rdy = 1; k++;
        end else begin
          chk(xfer_idx == exp_idx[k], "R5", "index", 32'(xfer_idx), 32'(exp_idx[k]));
          chk(xfer_addr == exp_addr[k], "R3", "address", xfer_addr, exp_addr[k]);
          chk(xfer_wr == !ld, "R2", "write flag", 32'(xfer_wr), 32'(!ld));
          if (poke && it == 1) begin
            start = 1; reg_mask = ~m; mem_rdy = 0;   // R10 stray start while busy
          end else begin
            mem_rdy = stall ? 1'($urandom_range(0, 2) != 0) : 1'b1;
            if (mem_rdy) k++;
          end
        end
      end else begin
        chk(0, "R8", "gap without done", 0, 1);
      end
      it++;
      @(negedge clk);
    end
    @(negedge clk);
    chk(!done && !xfer_vld && !busy, "R9", "after done", {29'd0, done, xfer_vld, busy}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R9", "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234abcd));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(!busy && !xfer_vld && !done && !wb_vld, "R1", "reset state",
        {28'd0, busy, xfer_vld, done, wb_vld}, 0);
    // R3 R6: IA from 1000 over R4,R6,R7,R8,R10 -> 1000..1016, base 1020
    run_op(16'h05D0, 1, 2'd0, 1, 32'd1000, 0, 0);
    // R5 R4: push R1,R3,R4,R5 (store, decrement-before, writeback)
    run_op(16'h003A, 0, 2'd3, 1, 32'h100, 0, 0);
    // pop the same set
    run_op(16'h003A, 1, 2'd0, 1, 32'hF0, 0, 0);
    // R7 empty mask, with and without writeback
    run_op(16'h0000, 0, 2'd3, 1, 32'h2000, 0, 0);
    run_op(16'h0000, 1, 2'd1, 0, 32'h2000, 0, 0);
    // full mask, all modes, stores
    for (int md = 0; md < 4; md++) run_op(16'hFFFF, 0, 2'(md), 1, 32'h8000, 1, 0);
    // R8 single register with stalls, R10 stray start
    run_op(16'h8000, 0, 2'd2, 1, 32'h40, 1, 0);
    run_op(16'h1248, 0, 2'd3, 1, 32'h4000, 0, 1);
    run_op(16'h1248, 1, 2'd1, 0, 32'h4000, 1, 1);
    // random mix
    for (int t = 0; t < 150; t++)
      run_op(16'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
             {$urandom_range(0, 32'h3FFF_FFFF), 2'b00}, 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule